// File: doc/BRIEF.md
# Serial Configuration Register Slave

This block lets an external host configure a serializer over a three-signal serial link: an active-low select, a serial clock and one shared data line. The host moves a 16-bit frame per access. The first eight bits carry a direction flag and a seven-bit register address. The last eight bits carry the data. For a read, the block takes over the shared line for the data half of the frame and returns the register contents. For a write, the line stays an input throughout, so a host that only writes never sees the block drive it. If the host keeps the select low after a write frame, each further byte goes to the next address.

The link inputs are oversampled by a fast system clock through synchronizers, so all state lives in one clock domain. A key register gates the rest of the bank. Only one exact key value opens it; while it is closed, other registers cannot be written and read as zero. The bank drives a lookup-table enable, a memory-unlock flag and a lane-count selection into the serializer. The lane selection only ever takes one of its two legal codes.

Top module: `spi_cfg_slave`

## Requirements
- R1: Frame bit 15 is the direction (1 = read, 0 = write), bits 14:8 the register address, and bits 7:0 the data. Bits travel MSB first and are taken on rising edges of the serial clock.
- R2: A write frame of exactly 16 bits stores its data byte at its address. The store occurs after the 16th rising edge.
- R3: The block drives the data line only during bits 8..15 of a read frame. It never drives the line during a write frame, and it releases the line when the select goes high.
- R4: The key register is at address 0x7F and is always writable and readable. Writing 0xFF opens access. Writing any value from 0x00 to 0xFE closes it. After reset it holds 0x00, so access is closed.
- R5: While access is closed, writes to any address other than 0x7F are ignored. Reads of any address other than 0x7F return 0x00.
- R6: On a read, the addressed byte is returned MSB first. The first bit is valid before the 9th rising edge, and each later bit changes only after a falling edge.
- R7: Each extra full byte sent while the select stays low after a write frame goes to the previous address plus one, wrapping from 0x7F to 0x00. Each byte is gated by the key value at the time it is stored.
- R8: If the select rises before a byte completes, that byte is discarded and no register changes. Bytes already completed in a page write are kept.
- R9: Register 0x00 resets to 0x00. Its bit 0 drives the lookup-table enable and its bit 4 drives the memory-unlock output.
- R10: Register 0x0A resets to 0x04. Its bits [2:0] pick the lane count: 010 for two lanes, 100 for three lanes. Any other code is stored and reads back as written, but the lane output keeps its last legal code.
- R11: Addresses 0x01 to 0x0F (apart from 0x0A) are plain read/write storage. Addresses 0x10 to 0x7E ignore writes and read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the link |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Active-low frame select from host |
| spi_sclk | input | 1 | Serial clock from host |
| spi_sdio_in | input | 1 | Data line as seen at the pad |
| spi_sdio_out | output | 1 | Read data bit presented to the pad |
| spi_sdio_oe | output | 1 | Pad output enable for the shared data line |
| lut_enable | output | 1 | Lookup-table enable (register 0x00 bit 0) |
| sram_unlock | output | 1 | Memory access unlock (register 0x00 bit 4) |
| lane_select | output | 3 | Effective lane-count code, always 010 or 100 |

## Verification
In a page write, the store of one byte and the gating of the next byte both depend on the key. The key decision for byte n+1 must therefore see the key value that byte n just stored. The bench provokes this with a page write that starts at 0x7F and wraps into 0x00. In one frame it opens the key and then writes register 0x00, which must take effect. In a second frame it closes the key and then writes register 0x00, which must be dropped. Both outcomes are judged at the output pins and by reading register 0x00 back after the key is reopened.

// File: rtl/spi_cfg_pkg.sv
package spi_cfg_pkg;

    localparam int ADDR_W  = 7;
    localparam int DATA_W  = 8;
    localparam int FRAME_W = 1 + ADDR_W + DATA_W;
    localparam int CNT_W   = $clog2(FRAME_W);
    localparam int LANE_W  = 3;

    localparam logic [ADDR_W-1:0] KEY_ADDR  = 7'h7F;
    localparam logic [ADDR_W-1:0] CTRL_ADDR = 7'h00;
    localparam logic [ADDR_W-1:0] LANE_ADDR = 7'h0A;
    localparam logic [DATA_W-1:0] KEY_OPEN  = 8'hFF;

    localparam logic [LANE_W-1:0] LANES_TWO   = 3'b010;
    localparam logic [LANE_W-1:0] LANES_THREE = 3'b100;

    localparam int CTRL_LUT_BIT  = 0;
    localparam int CTRL_SRAM_BIT = 4;

    typedef struct packed {
        logic                sclk_prev;
        logic [CNT_W-1:0]    cnt;
        logic                head;
        logic                is_rd;
        logic                done;
        logic [ADDR_W-1:0]   addr;
        logic [DATA_W-1:0]   shin;
        logic [DATA_W-1:0]   shout;
        logic                oe;
        logic                load;
        logic                arm;
        logic                wr_en;
        logic [ADDR_W-1:0]   wr_addr;
        logic [DATA_W-1:0]   wr_data;
    } frame_t;

endpackage

// File: rtl/spi_cfg_sync.sv
module spi_cfg_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    for (genvar g = 0; g < WIDTH; g++) begin : g_bit
        logic [STAGES-1:0] chain_q;
        logic [STAGES-1:0] chain_d;

        always_comb begin
            chain_d = {chain_q[STAGES-2:0], async_in[g]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chain_q <= {STAGES{RST_VAL[g]}};
            end else begin
                chain_q <= chain_d;
            end
        end

        assign sync_out[g] = chain_q[STAGES-1];
    end

endmodule

// File: rtl/spi_cfg_frame.sv
module spi_cfg_frame
    import spi_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_s,
    input  logic              sclk_s,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              sdo,
    output logic              oe,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam logic [CNT_W-1:0] CMD_LAST   = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] BYTE_FIRST = CNT_W'(FRAME_W - DATA_W);

    frame_t q, d;

    logic sclk_rise;
    logic sclk_fall;
    logic [ADDR_W-1:0] next_addr;

    always_comb begin
        sclk_rise = sclk_s & ~q.sclk_prev;
        sclk_fall = ~sclk_s & q.sclk_prev;
        next_addr = q.head ? q.addr : q.addr + 1'b1;

        d           = q;
        d.sclk_prev = sclk_s;
        d.wr_en     = 1'b0;

        if (cs_s) begin
            d.cnt   = '0;
            d.head  = 1'b1;
            d.is_rd = 1'b0;
            d.done  = 1'b0;
            d.oe    = 1'b0;
            d.load  = 1'b0;
            d.arm   = 1'b0;
        end else begin
            if (q.load) begin
                d.shout = rd_data;
                d.oe    = 1'b1;
                d.load  = 1'b0;
            end
            if (sclk_fall && q.arm) begin
                d.shout = {q.shout[DATA_W-2:0], 1'b0};
                d.arm   = 1'b0;
            end
            if (sclk_rise && !q.done) begin
                d.shin = {q.shin[DATA_W-2:0], sdi_s};
                d.cnt  = q.cnt + 1'b1;
                if (q.head && q.cnt == CMD_LAST) begin
                    d.is_rd = q.shin[ADDR_W-1];
                    d.addr  = {q.shin[ADDR_W-2:0], sdi_s};
                    d.load  = q.shin[ADDR_W-1];
                end
                if (q.cnt == FRAME_LAST) begin
                    if (q.is_rd) begin
                        d.oe   = 1'b0;
                        d.arm  = 1'b0;
                        d.done = 1'b1;
                    end else begin
                        d.wr_en   = 1'b1;
                        d.wr_addr = next_addr;
                        d.wr_data = {q.shin[DATA_W-2:0], sdi_s};
                        d.addr    = next_addr;
                        d.head    = 1'b0;
                        d.cnt     = BYTE_FIRST;
                    end
                end else if (q.is_rd && q.oe) begin
                    d.arm = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.head <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign rd_addr = q.addr;
    assign sdo     = q.shout[DATA_W-1];
    assign oe      = q.oe;
    assign wr_en   = q.wr_en;
    assign wr_addr = q.wr_addr;
    assign wr_data = q.wr_data;

endmodule

// File: rtl/spi_cfg_regbank.sv
module spi_cfg_regbank
    import spi_cfg_pkg::*;
#(
    parameter int REG_COUNT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              access_en,
    output logic              lut_enable,
    output logic              sram_unlock,
    output logic [LANE_W-1:0] lane_select
);

    localparam int IDX_W = $clog2(REG_COUNT);
    localparam logic [ADDR_W-1:0] LIMIT = ADDR_W'(REG_COUNT);
    localparam logic [DATA_W-1:0] LANE_RESET = {{(DATA_W-LANE_W){1'b0}}, LANES_THREE};

    typedef struct packed {
        logic [REG_COUNT-1:0][DATA_W-1:0] regs;
        logic [DATA_W-1:0]                key;
        logic [LANE_W-1:0]                lane_eff;
    } bank_t;

    function automatic logic [REG_COUNT-1:0][DATA_W-1:0] reset_image();
        logic [REG_COUNT-1:0][DATA_W-1:0] img;
        img = '0;
        img[LANE_ADDR[IDX_W-1:0]] = LANE_RESET;
        return img;
    endfunction

    bank_t q, d;

    logic              open_now;
    logic              wr_in_bank;
    logic              lane_legal;
    logic [IDX_W-1:0]  wr_idx;
    logic [IDX_W-1:0]  rd_idx;

    always_comb begin
        open_now   = (q.key == KEY_OPEN);
        wr_in_bank = (wr_addr < LIMIT);
        wr_idx     = wr_addr[IDX_W-1:0];
        rd_idx     = rd_addr[IDX_W-1:0];
        lane_legal = (wr_data[LANE_W-1:0] == LANES_TWO) ||
                     (wr_data[LANE_W-1:0] == LANES_THREE);

        d = q;
        if (wr_en) begin
            if (wr_addr == KEY_ADDR) begin
                d.key = wr_data;
            end else if (open_now && wr_in_bank) begin
                d.regs[wr_idx] = wr_data;
                if (wr_addr == LANE_ADDR && lane_legal) begin
                    d.lane_eff = wr_data[LANE_W-1:0];
                end
            end
        end

        if (rd_addr == KEY_ADDR) begin
            rd_data = q.key;
        end else if (open_now && rd_addr < LIMIT) begin
            rd_data = q.regs[rd_idx];
        end else begin
            rd_data = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q.regs     <= reset_image();
            q.key      <= '0;
            q.lane_eff <= LANES_THREE;
        end else begin
            q <= d;
        end
    end

    assign access_en   = (q.key == KEY_OPEN);
    assign lut_enable  = q.regs[CTRL_ADDR[IDX_W-1:0]][CTRL_LUT_BIT];
    assign sram_unlock = q.regs[CTRL_ADDR[IDX_W-1:0]][CTRL_SRAM_BIT];
    assign lane_select = q.lane_eff;

endmodule

// File: rtl/spi_cfg_slave.sv
module spi_cfg_slave
    import spi_cfg_pkg::*;
#(
    parameter int REG_COUNT   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              spi_cs_n,
    input  logic              spi_sclk,
    input  logic              spi_sdio_in,
    output logic              spi_sdio_out,
    output logic              spi_sdio_oe,
    output logic              lut_enable,
    output logic              sram_unlock,
    output logic [LANE_W-1:0] lane_select
);

    logic [2:0]        pins_s;
    logic              cs_s;
    logic              sclk_s;
    logic              sdi_s;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;
    logic              access_en;

    spi_cfg_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({spi_cs_n, spi_sclk, spi_sdio_in}),
        .sync_out (pins_s)
    );

    assign cs_s   = pins_s[2];
    assign sclk_s = pins_s[1];
    assign sdi_s  = pins_s[0];

    spi_cfg_frame u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_s    (cs_s),
        .sclk_s  (sclk_s),
        .sdi_s   (sdi_s),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .sdo     (spi_sdio_out),
        .oe      (spi_sdio_oe),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    spi_cfg_regbank #(
        .REG_COUNT (REG_COUNT)
    ) u_bank (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .wr_addr     (wr_addr),
        .wr_data     (wr_data),
        .rd_addr     (rd_addr),
        .rd_data     (rd_data),
        .access_en   (access_en),
        .lut_enable  (lut_enable),
        .sram_unlock (sram_unlock),
        .lane_select (lane_select)
    );

endmodule

// File: rtl/spi_cfg_slave_chk.sv
module spi_cfg_slave_chk
    import spi_cfg_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              cs_s,
    input logic              spi_sdio_oe,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [DATA_W-1:0] wr_data,
    input logic              access_en,
    input logic              lut_enable,
    input logic              sram_unlock,
    input logic [LANE_W-1:0] lane_select
);

    p_release_on_deselect_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cs_s |=> !spi_sdio_oe);

    p_no_drive_on_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !spi_sdio_oe);

    p_key_opens_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == KEY_ADDR && wr_data == KEY_OPEN) |=> access_en);

    p_key_closes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == KEY_ADDR && wr_data != KEY_OPEN) |=> !access_en);

    p_locked_outputs_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !access_en |=> ($stable(lut_enable) && $stable(sram_unlock) && $stable(lane_select)));

    p_lane_code_legal_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (lane_select == LANES_TWO) || (lane_select == LANES_THREE));

    p_store_needs_select_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$past(cs_s));

endmodule

bind spi_cfg_slave spi_cfg_slave_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cs_s        (cs_s),
    .spi_sdio_oe (spi_sdio_oe),
    .wr_en       (wr_en),
    .wr_addr     (wr_addr),
    .wr_data     (wr_data),
    .access_en   (access_en),
    .lut_enable  (lut_enable),
    .sram_unlock (sram_unlock),
    .lane_select (lane_select)
);

// File: tb/test_spi_cfg_slave.sv
module test_spi_cfg_slave;

    localparam int HALF   = 8;
    localparam int NVEC   = 19;
    localparam int WDOG   = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       spi_cs_n = 1'b1;
    logic       spi_sclk = 1'b0;
    logic       spi_sdio_in = 1'b0;
    logic       spi_sdio_out;
    logic       spi_sdio_oe;
    logic       lut_enable;
    logic       sram_unlock;
    logic [2:0] lane_select;

    int  checks = 0;
    int  failures = 0;
    int  oe_on_write = 0;
    bit  in_write = 1'b0;
    bit  finished = 1'b0;

    always #10 clk = ~clk;

    spi_cfg_slave i_spi_cfg_slave (
        .clk          (clk),
        .rst_n        (rst_n),
        .spi_cs_n     (spi_cs_n),
        .spi_sclk     (spi_sclk),
        .spi_sdio_in  (spi_sdio_in),
        .spi_sdio_out (spi_sdio_out),
        .spi_sdio_oe  (spi_sdio_oe),
        .lut_enable   (lut_enable),
        .sram_unlock  (sram_unlock),
        .lane_select  (lane_select)
    );

    always @(negedge clk) begin
        if (in_write && spi_sdio_oe) oe_on_write++;
    end

    // {is_read, addr[6:0], data[7:0], expected[7:0]}
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b1, 7'h7F, 8'h00, 8'h00},   // R4 key resets to 0x00
        {1'b1, 7'h0A, 8'h00, 8'h00},   // R5 locked read returns 0
        {1'b0, 7'h05, 8'h5A, 8'h00},   // R5 locked write dropped
        {1'b0, 7'h7F, 8'hFF, 8'h00},   // R4 open
        {1'b1, 7'h7F, 8'h00, 8'hFF},   // R4 key readback
        {1'b1, 7'h0A, 8'h00, 8'h04},   // R10 lane reset value
        {1'b1, 7'h05, 8'h00, 8'h00},   // R5 earlier write had no effect
        {1'b0, 7'h05, 8'hA5, 8'h00},   // R2
        {1'b1, 7'h05, 8'h00, 8'hA5},   // R2 R1 R6
        {1'b0, 7'h0F, 8'h3C, 8'h00},   // R11
        {1'b1, 7'h0F, 8'h00, 8'h3C},   // R11
        {1'b1, 7'h20, 8'h00, 8'h00},   // R11 unmapped reads 0
        {1'b0, 7'h20, 8'h77, 8'h00},   // R11 unmapped write
        {1'b1, 7'h20, 8'h00, 8'h00},   // R11 still 0
        {1'b0, 7'h7F, 8'hFE, 8'h00},   // R4 close with 0xFE
        {1'b1, 7'h05, 8'h00, 8'h00},   // R5 locked read
        {1'b1, 7'h7F, 8'h00, 8'hFE},   // R4 key readable while closed
        {1'b0, 7'h7F, 8'hFF, 8'h00},   // R4 reopen
        {1'b1, 7'h05, 8'h00, 8'hA5}    // R5 contents kept while locked
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic xbits(input logic [7:0] b, input int n,
                         output logic [7:0] r, output logic oe_all);
        r = '0;
        oe_all = 1'b1;
        for (int i = 0; i < n; i++) begin
            spi_sdio_in = b[7-i];
            repeat (HALF) @(negedge clk);
            r = {r[6:0], spi_sdio_out};
            oe_all = oe_all & spi_sdio_oe;
            spi_sclk = 1'b1;
            repeat (HALF) @(negedge clk);
            spi_sclk = 1'b0;
        end
    endtask

    task automatic sel_lo();
        @(negedge clk);
        spi_cs_n = 1'b0;
        repeat (HALF) @(negedge clk);
    endtask

    task automatic sel_hi();
        repeat (HALF) @(negedge clk);
        spi_cs_n = 1'b1;
        repeat (2 * HALF) @(negedge clk);
    endtask

    task automatic write_reg(input logic [6:0] a, input logic [7:0] v);
        logic [7:0] junk;
        logic       o;
        in_write = 1'b1;
        sel_lo();
        xbits({1'b0, a}, 8, junk, o);
        xbits(v, 8, junk, o);
        sel_hi();
        in_write = 1'b0;
    endtask

    task automatic read_reg(input logic [6:0] a, output logic [7:0] v, output logic oe_ok);
        logic [7:0] junk;
        logic       o;
        sel_lo();
        xbits({1'b1, a}, 8, junk, o);
        xbits(8'h00, 8, v, oe_ok);
        sel_hi();
    endtask

    task automatic finish_run();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    endtask

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL R1 watchdog actual=running expected=done");
            finish_run();
        end
    end

    initial begin
        logic [7:0] rv;
        logic       ok;
        logic [7:0] junk;
        logic       o;

        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // reset state
        check("R9 reset lut_enable", lut_enable, 0);
        check("R9 reset sram_unlock", sram_unlock, 0);
        check("R10 reset lane_select", lane_select, 3'b100);
        check("R3 reset oe", spi_sdio_oe, 0);

        // vector table
        for (int i = 0; i < NVEC; i++) begin
            if (VEC[i][23]) begin
                read_reg(VEC[i][22:16], rv, ok);
                check($sformatf("R1 table[%0d] read data", i), rv, VEC[i][7:0]);
                check($sformatf("R6 table[%0d] line driven", i), ok, 1);
            end else begin
                write_reg(VEC[i][22:16], VEC[i][15:8]);
            end
        end
        check("R3 no drive during writes", oe_on_write, 0);

        // R8 early termination: 10 bits and 15 bits
        in_write = 1'b1;
        sel_lo();
        xbits({1'b0, 7'h05}, 8, junk, o);
        xbits(8'h00, 2, junk, o);
        sel_hi();
        sel_lo();
        xbits({1'b0, 7'h0A}, 8, junk, o);
        xbits(8'h02, 7, junk, o);
        sel_hi();
        in_write = 1'b0;
        read_reg(7'h05, rv, ok);
        check("R8 short frame left 0x05", rv, 8'hA5);
        read_reg(7'h0A, rv, ok);
        check("R8 short frame left 0x0A", rv, 8'h04);
        check("R8 short frame lane pin", lane_select, 3'b100);

        // R9 control register
        write_reg(7'h00, 8'h11);
        check("R9 lut_enable set", lut_enable, 1);
        check("R9 sram_unlock set", sram_unlock, 1);
        read_reg(7'h00, rv, ok);
        check("R9 ctrl readback", rv, 8'h11);

        // R10 lane codes
        write_reg(7'h0A, 8'h02);
        check("R10 two lanes", lane_select, 3'b010);
        write_reg(7'h0A, 8'h07);
        check("R10 reserved code holds lanes", lane_select, 3'b010);
        read_reg(7'h0A, rv, ok);
        check("R10 reserved code stored", rv, 8'h07);
        write_reg(7'h0A, 8'h04);
        check("R10 three lanes", lane_select, 3'b100);

        // R7 page write with trailing partial byte (R8)
        in_write = 1'b1;
        sel_lo();
        xbits({1'b0, 7'h03}, 8, junk, o);
        xbits(8'h11, 8, junk, o);
        xbits(8'h22, 8, junk, o);
        xbits(8'h33, 8, junk, o);
        xbits(8'hAB, 4, junk, o);
        sel_hi();
        in_write = 1'b0;
        read_reg(7'h03, rv, ok);
        check("R7 page byte 0", rv, 8'h11);
        read_reg(7'h04, rv, ok);
        check("R7 page byte 1", rv, 8'h22);
        read_reg(7'h05, rv, ok);
        check("R7 page byte 2", rv, 8'h33);
        read_reg(7'h06, rv, ok);
        check("R8 page partial byte dropped", rv, 8'h00);

        // R7 wrap: key opened then register 0x00 in one frame
        write_reg(7'h7F, 8'hFE);
        in_write = 1'b1;
        sel_lo();
        xbits({1'b0, 7'h7F}, 8, junk, o);
        xbits(8'hFF, 8, junk, o);
        xbits(8'h66, 8, junk, o);
        sel_hi();
        in_write = 1'b0;
        check("R7 wrap write lut_enable", lut_enable, 0);
        check("R7 wrap write sram_unlock", sram_unlock, 0);
        read_reg(7'h00, rv, ok);
        check("R7 wrap into 0x00", rv, 8'h66);

        // R5 key closed then register 0x00 in one frame
        in_write = 1'b1;
        sel_lo();
        xbits({1'b0, 7'h7F}, 8, junk, o);
        xbits(8'h00, 8, junk, o);
        xbits(8'h11, 8, junk, o);
        sel_hi();
        in_write = 1'b0;
        check("R5 closed-key page lut pin", lut_enable, 0);
        read_reg(7'h00, rv, ok);
        check("R5 closed read of 0x00", rv, 8'h00);
        write_reg(7'h7F, 8'hFF);
        read_reg(7'h00, rv, ok);
        check("R5 closed-key page byte dropped", rv, 8'h66);
        check("R3 no drive during later writes", oe_on_write, 0);

        finish_run();
    end

endmodule